// File: doc/BRIEF.md
# Banked VGA Aperture Memory Mapper

This block sits between a 128 KB host byte aperture and a 4 MB video memory. While an extended colour mode is active, it turns each host byte access into a video-memory access. Reads and writes use separate 64 KB bank numbers. Two layouts are supported: a packed layout, in which the aperture is a linear byte window, and a planar layout, in which each host byte selects one 32-bit word of four plane bytes. When no extended mode is active, the block forwards the access unchanged to a legacy path and does not touch video memory.

The video-memory port is one word wide, with one byte lane per plane and a write enable per lane. A planar write with several planes enabled occupies the port for one cycle per plane. During that burst the block raises `busy`, and it ignores any host strobe presented while `busy` is high. Read data comes back at a fixed latency with a valid pulse.

Top module: `vga_bank_mapper`

## Requirements
- R1: While `rst` is high, `vm_we`, `vm_re`, `busy`, `host_rvalid`, `legacy_rd` and `legacy_wr` are all low.
- R2: With `chain4` high, the byte address is `bank*0x10000 + host_addr[15:0]`. `vm_addr` is that byte address divided by 4, and the byte sits in lane `byte_address[1:0]`. Lane i is bits 8i+7..8i of `vm_wdata`/`vm_rdata` and bit i of `vm_be`.
- R3: With `chain4` low, plane i is word `host_addr[15:0] + bank*0x4000`, lane i (byte address `host_addr*4 + i + bank*0x10000`).
- R4: A planar write stores `host_wdata` into every plane enabled in `map_mask`. It issues one lane per cycle in ascending plane order, and `busy` stays high for (number of enabled planes − 1) cycles.
- R5: A planar read returns the OR of the bytes of all planes enabled in `map_mask`. An empty mask returns 0.
- R6: Writes use `bank_wr` and reads use `bank_rd`.
- R7: Addresses wrap modulo the 4 MB video-memory size.
- R8: With `ext_en` high and `host_addr[16]` set, a write makes no memory access. A read makes no memory access and returns 0 with the normal latency.
- R9: With `ext_en` low, a strobe appears on `legacy_rd`/`legacy_wr` one cycle later, with `legacy_addr` and `legacy_wdata` equal to the host values. There is no memory access and no `host_rvalid`.
- R10: A read sampled at clock edge k gives `host_rvalid` high for one cycle after edge k+2, with the data on `host_rdata`.
- R11: A strobe sampled while `busy` is high is ignored.
- R12: If `host_rd` and `host_wr` are high together, the write is performed and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 17 | Offset within the host aperture |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write byte |
| bank_rd | input | 6 | 64 KB bank for reads |
| bank_wr | input | 6 | 64 KB bank for writes |
| chain4 | input | 1 | 1 = packed linear layout, 0 = planar |
| map_mask | input | 4 | Planes enabled in planar mode |
| ext_en | input | 1 | An extended colour mode is active |
| busy | output | 1 | Planar write burst still in progress |
| host_rdata | output | 8 | Read byte |
| host_rvalid | output | 1 | Read byte valid |
| vm_addr | output | 20 | Video-memory word address |
| vm_we | output | 1 | Video-memory write |
| vm_be | output | 4 | Lane write enables |
| vm_wdata | output | 32 | Write word (byte replicated) |
| vm_re | output | 1 | Video-memory read |
| vm_rdata | input | 32 | Read word, valid the cycle after `vm_re` is sampled |
| legacy_rd | output | 1 | Forwarded read strobe |
| legacy_wr | output | 1 | Forwarded write strobe |
| legacy_addr | output | 17 | Forwarded offset |
| legacy_wdata | output | 8 | Forwarded write byte |

## Verification
The delicate overlap is a read whose strobe is sampled in the same cycle that the last lane of a planar write is still being committed: `busy` has just fallen, but that lane's write is only now reaching memory. The bench provokes this by presenting a planar read at the first falling edge where `busy` is low, with the mask selecting only the last written plane. It then expects the new byte, not the stale one. A second overlap, simultaneous read and write strobes, is judged by the write landing in memory while no read strobe reaches memory and no valid pulse appears.

// File: rtl/vbm_pkg.sv
package vbm_pkg;
  localparam int PLANES = 4;
  localparam int LANE_W = $clog2(PLANES);
  localparam int BYTE_W = 8;

  typedef logic [PLANES-1:0] plane_mask_t;

  // isolate the least significant set plane bit
  function automatic plane_mask_t lowest_plane(input plane_mask_t m);
    return m & (~m + plane_mask_t'(1));
  endfunction
endpackage

// File: rtl/vbm_addr_map.sv
module vbm_addr_map
  import vbm_pkg::*;
#(
  parameter int WIN_W  = 16,
  parameter int BANK_W = 6,
  parameter int VM_AW  = 22,
  localparam int WORD_AW = VM_AW - LANE_W
) (
  input  logic [WIN_W-1:0]   win,
  input  logic [BANK_W-1:0]  bank,
  input  logic               chain4,
  output logic [WORD_AW-1:0] word,
  output plane_mask_t        lane_oh
);
  logic [VM_AW-1:0]   lin_byte;
  logic [WORD_AW-1:0] pl_word;

  always_comb begin
    // packed: one byte per aperture offset, bank steps of the window size
    lin_byte = VM_AW'({bank, {WIN_W{1'b0}}}) + VM_AW'(win);
    // planar: one word per offset, so the bank step shrinks by the lane count
    pl_word  = WORD_AW'({bank, {(WIN_W-LANE_W){1'b0}}}) + WORD_AW'(win);
    if (chain4) begin
      word    = lin_byte[VM_AW-1:LANE_W];
      lane_oh = plane_mask_t'(1) << lin_byte[LANE_W-1:0];
    end else begin
      word    = pl_word;
      lane_oh = '0;
    end
  end
endmodule

// File: rtl/vbm_plane_seq.sv
module vbm_plane_seq
  import vbm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  plane_mask_t start_mask,
  output plane_mask_t first_be,
  output plane_mask_t cont_be,
  output logic        busy
);
  plane_mask_t rem_q;

  assign first_be = lowest_plane(start_mask);
  assign cont_be  = lowest_plane(rem_q);
  assign busy     = |rem_q;

  always_ff @(posedge clk) begin
    if (rst)        rem_q <= '0;
    else if (start) rem_q <= start_mask & ~first_be;
    else            rem_q <= rem_q & ~cont_be;
  end
endmodule

// File: rtl/vbm_read_merge.sv
module vbm_read_merge
  import vbm_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pend,
  input  logic                     zero,
  input  plane_mask_t              mask,
  input  logic [PLANES*BYTE_W-1:0] vm_rdata,
  output logic [BYTE_W-1:0]        rdata,
  output logic                     rvalid
);
  logic        pend_d, zero_d;
  plane_mask_t mask_d;
  logic [BYTE_W-1:0] merged;

  always_comb begin
    merged = '0;
    for (int i = 0; i < PLANES; i++)
      if (mask_d[i]) merged = merged | vm_rdata[i*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_d <= 1'b0;
      zero_d <= 1'b0;
      mask_d <= '0;
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      pend_d <= pend;
      zero_d <= zero;
      mask_d <= mask;
      rvalid <= pend_d;
      if (pend_d) rdata <= zero_d ? '0 : merged;
    end
  end
endmodule

// File: rtl/vga_bank_mapper.sv
module vga_bank_mapper
  import vbm_pkg::*;
#(
  parameter int OFS_W  = 17,
  parameter int BANK_W = 6,
  parameter int VM_AW  = 22,
  localparam int WIN_W   = OFS_W - 1,
  localparam int WORD_AW = VM_AW - LANE_W,
  localparam int BUS_W   = PLANES * BYTE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OFS_W-1:0]   host_addr,
  input  logic               host_rd,
  input  logic               host_wr,
  input  logic [BYTE_W-1:0]  host_wdata,
  input  logic [BANK_W-1:0]  bank_rd,
  input  logic [BANK_W-1:0]  bank_wr,
  input  logic               chain4,
  input  logic [PLANES-1:0]  map_mask,
  input  logic               ext_en,
  output logic               busy,
  output logic [BYTE_W-1:0]  host_rdata,
  output logic               host_rvalid,
  output logic [WORD_AW-1:0] vm_addr,
  output logic               vm_we,
  output logic [PLANES-1:0]  vm_be,
  output logic [BUS_W-1:0]   vm_wdata,
  output logic               vm_re,
  input  logic [BUS_W-1:0]   vm_rdata,
  output logic               legacy_rd,
  output logic               legacy_wr,
  output logic [OFS_W-1:0]   legacy_addr,
  output logic [BYTE_W-1:0]  legacy_wdata
);
  logic [WORD_AW-1:0] wr_word, rd_word;
  plane_mask_t        wr_lane, rd_lane, first_be, cont_be;
  logic               seq_busy;
  logic               take, upper, do_wr, do_rd, seq_start;
  logic               rd_pend_q, rd_zero_q;
  plane_mask_t        rd_mask_q;

  vbm_addr_map #(.WIN_W(WIN_W), .BANK_W(BANK_W), .VM_AW(VM_AW)) u_wr_map (
    .win(host_addr[WIN_W-1:0]), .bank(bank_wr), .chain4(chain4),
    .word(wr_word), .lane_oh(wr_lane)
  );

  vbm_addr_map #(.WIN_W(WIN_W), .BANK_W(BANK_W), .VM_AW(VM_AW)) u_rd_map (
    .win(host_addr[WIN_W-1:0]), .bank(bank_rd), .chain4(chain4),
    .word(rd_word), .lane_oh(rd_lane)
  );

  vbm_plane_seq u_seq (
    .clk(clk), .rst(rst), .start(seq_start), .start_mask(map_mask),
    .first_be(first_be), .cont_be(cont_be), .busy(seq_busy)
  );

  vbm_read_merge u_merge (
    .clk(clk), .rst(rst), .pend(rd_pend_q), .zero(rd_zero_q),
    .mask(rd_mask_q), .vm_rdata(vm_rdata),
    .rdata(host_rdata), .rvalid(host_rvalid)
  );

  assign busy      = seq_busy;
  assign take      = !seq_busy && (host_rd || host_wr);
  assign upper     = host_addr[OFS_W-1];
  assign do_wr     = take && ext_en && host_wr && !upper;
  assign do_rd     = take && ext_en && !host_wr && host_rd;
  assign seq_start = do_wr && !chain4;

  always_ff @(posedge clk) begin
    if (rst) begin
      vm_addr      <= '0;
      vm_we        <= 1'b0;
      vm_be        <= '0;
      vm_wdata     <= '0;
      vm_re        <= 1'b0;
      legacy_rd    <= 1'b0;
      legacy_wr    <= 1'b0;
      legacy_addr  <= '0;
      legacy_wdata <= '0;
      rd_pend_q    <= 1'b0;
      rd_zero_q    <= 1'b0;
      rd_mask_q    <= '0;
    end else begin
      // burst continuation lanes reuse the held address and data
      vm_we     <= |cont_be;
      vm_be     <= cont_be;
      vm_re     <= 1'b0;
      legacy_rd <= 1'b0;
      legacy_wr <= 1'b0;
      rd_pend_q <= 1'b0;

      if (take && !ext_en) begin
        legacy_wr    <= host_wr;
        legacy_rd    <= host_rd && !host_wr;
        legacy_addr  <= host_addr;
        legacy_wdata <= host_wdata;
      end

      if (do_wr) begin
        vm_addr  <= wr_word;
        vm_wdata <= {PLANES{host_wdata}};
        if (chain4) begin
          vm_we <= 1'b1;
          vm_be <= wr_lane;
        end else begin
          vm_we <= |map_mask;
          vm_be <= first_be;
        end
      end

      if (do_rd) begin
        rd_pend_q <= 1'b1;
        rd_zero_q <= upper;
        rd_mask_q <= chain4 ? rd_lane : map_mask;
        if (!upper) begin
          vm_re   <= 1'b1;
          vm_addr <= rd_word;
        end
      end
    end
  end
endmodule

// File: rtl/vbm_checker.sv
module vbm_checker #(
  parameter int OFS_W = 17
) (
  input logic             clk,
  input logic             rst,
  input logic [OFS_W-1:0] host_addr,
  input logic             host_rd,
  input logic             host_wr,
  input logic             ext_en,
  input logic             busy,
  input logic             vm_we,
  input logic             vm_re,
  input logic [3:0]       vm_be,
  input logic             host_rvalid,
  input logic             legacy_wr
);
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !host_wr && !busy && ext_en) |-> ##3 host_rvalid); // R10

  AST_UPPER_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (host_wr && ext_en && !busy && host_addr[OFS_W-1]) |=> !vm_we); // R8

  AST_UPPER_NO_READ: assert property (@(posedge clk) disable iff (rst)
    (host_rd && ext_en && !busy && host_addr[OFS_W-1]) |=> !vm_re); // R8

  AST_LEGACY_FORWARD: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !ext_en && !busy) |=> (legacy_wr && !vm_we)); // R9

  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
    (busy && host_rd) |=> !vm_re); // R11

  AST_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
    vm_we |-> ($countones(vm_be) == 1)); // R4

  AST_BURST_FEEDS: assert property (@(posedge clk) disable iff (rst)
    busy |=> vm_we); // R4

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_wr && !busy) |=> !vm_re); // R12
endmodule

bind vga_bank_mapper vbm_checker #(.OFS_W(OFS_W)) u_vbm_checker (
  .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd),
  .host_wr(host_wr), .ext_en(ext_en), .busy(busy), .vm_we(vm_we),
  .vm_re(vm_re), .vm_be(vm_be), .host_rvalid(host_rvalid),
  .legacy_wr(legacy_wr)
);

// File: tb/test_vga_bank_mapper.sv
module test_vga_bank_mapper;
  import vbm_pkg::*;

  logic        clk = 1'b0;
  logic        rst;
  logic [16:0] host_addr;
  logic        host_rd, host_wr;
  logic [7:0]  host_wdata;
  logic [5:0]  bank_rd, bank_wr;
  logic        chain4;
  logic [3:0]  map_mask;
  logic        ext_en;
  logic        busy;
  logic [7:0]  host_rdata;
  logic        host_rvalid;
  logic [19:0] vm_addr;
  logic        vm_we, vm_re;
  logic [3:0]  vm_be;
  logic [31:0] vm_wdata, vm_rdata;
  logic        legacy_rd, legacy_wr;
  logic [16:0] legacy_addr;
  logic [7:0]  legacy_wdata;

  vga_bank_mapper i_vga_bank_mapper (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .bank_rd(bank_rd),
    .bank_wr(bank_wr), .chain4(chain4), .map_mask(map_mask), .ext_en(ext_en),
    .busy(busy), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .vm_addr(vm_addr), .vm_we(vm_we), .vm_be(vm_be), .vm_wdata(vm_wdata),
    .vm_re(vm_re), .vm_rdata(vm_rdata), .legacy_rd(legacy_rd),
    .legacy_wr(legacy_wr), .legacy_addr(legacy_addr), .legacy_wdata(legacy_wdata)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int wr_cnt = 0, re_cnt = 0, busy_cyc = 0;
  logic [3:0]  be_log[$];
  logic [7:0]  mem[int];
  logic [7:0]  exp_q[$];
  string       tag_q[$];

  function automatic logic [7:0] pat(int w, int l);
    return 8'((w * 13 + l * 61 + 5) & 255);
  endfunction

  function automatic logic [7:0] memb(int w, int l);
    if (mem.exists(w * 4 + l)) return mem[w * 4 + l];
    return pat(w, l);
  endfunction

  function automatic int lin_b(int bank, int off);
    return (bank * 65536 + (off & 65535)) % 4194304;
  endfunction

  function automatic int pl_w(int bank, int off);
    return (bank * 16384 + (off & 65535)) % 1048576;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // video memory model: one-cycle synchronous read, byte-lane writes
  always @(posedge clk) begin
    logic [31:0] word_v;
    if (vm_we) begin
      wr_cnt++;
      be_log.push_back(vm_be);
      for (int l = 0; l < 4; l++)
        if (vm_be[l]) mem[int'(vm_addr) * 4 + l] = vm_wdata[8*l +: 8];
    end
    if (vm_re) begin
      re_cnt++;
      for (int l = 0; l < 4; l++) word_v[8*l +: 8] = memb(int'(vm_addr), l);
      vm_rdata <= word_v;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && busy) busy_cyc++;
    if (!rst && host_rvalid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R11/R12 unexpected read valid: actual 1 expected 0");
      end else begin
        chk(tag_q.pop_front(), "read data", host_rdata, exp_q.pop_front());
      end
    end
  end

  // called at a falling edge, returns at a falling edge
  task automatic wr(input int off, input int bank, input logic c4,
                    input logic [3:0] mask, input logic [7:0] d, input logic settle);
    host_addr = 17'(off); bank_wr = 6'(bank); chain4 = c4; map_mask = mask;
    host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
    while (busy) @(negedge clk);
    if (settle) @(negedge clk);
  endtask

  task automatic rd(input int off, input int bank, input logic c4,
                    input logic [3:0] mask, input logic [7:0] exp, input string tag);
    host_addr = 17'(off); bank_rd = 6'(bank); chain4 = c4; map_mask = mask;
    host_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); host_rd = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R10", "valid latency", host_rvalid, 1'b1);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int w, b, wc, rc;
    rst = 1'b1; host_rd = 0; host_wr = 0; host_addr = '0; host_wdata = '0;
    bank_rd = '0; bank_wr = '0; chain4 = 1'b1; map_mask = '0; ext_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "reset outputs", {vm_we, vm_re, busy, host_rvalid, legacy_rd, legacy_wr}, 6'b0);
    rst = 1'b0;
    @(negedge clk);

    // packed write, read bank kept different
    bank_rd = 6'd3;
    wr(17'h01236, 5, 1'b1, 4'h0, 8'hA5, 1'b1);
    b = lin_b(5, 'h1236);
    chk("R2", "packed byte", memb(b / 4, b % 4), 8'hA5);
    chk("R2", "neighbour lane", memb(b / 4, (b % 4) ^ 1), pat(b / 4, (b % 4) ^ 1));
    b = lin_b(3, 'h1236);
    chk("R6", "read bank untouched", memb(b / 4, b % 4), pat(b / 4, b % 4));

    bank_wr = 6'd9;
    rd(17'h01236, 5, 1'b1, 4'h0, 8'hA5, "R6");
    b = lin_b(9, 'h1236);
    rd(17'h01236, 9, 1'b1, 4'h0, pat(b / 4, b % 4), "R2");

    // planar write burst
    be_log.delete(); wc = wr_cnt; busy_cyc = 0;
    wr(17'h00100, 2, 1'b0, 4'b1011, 8'h3C, 1'b1);
    chk("R4", "lane writes", wr_cnt - wc, 3);
    chk("R4", "busy cycles", busy_cyc, 2);
    chk("R4", "lane order 0", be_log[0], 4'b0001);
    chk("R4", "lane order 1", be_log[1], 4'b0010);
    chk("R4", "lane order 2", be_log[2], 4'b1000);
    w = pl_w(2, 'h100);
    chk("R3", "plane 0", memb(w, 0), 8'h3C);
    chk("R3", "plane 3", memb(w, 3), 8'h3C);
    chk("R3", "plane 2 masked", memb(w, 2), pat(w, 2));

    rd(17'h00100, 2, 1'b0, 4'b0110, 8'h3C | pat(w, 2), "R5");
    rd(17'h00100, 2, 1'b0, 4'b0000, 8'h00, "R5");

    // wrap past the top of memory
    wr(17'h0FFFF, 63, 1'b0, 4'b0001, 8'h77, 1'b1);
    chk("R7", "wrapped word", memb(pl_w(63, 'hFFFF), 0), 8'h77);
    rd(17'h0FFFF, 63, 1'b0, 4'b0001, 8'h77, "R7");

    // upper half of aperture
    wc = wr_cnt; rc = re_cnt;
    wr(17'h10010, 2, 1'b1, 4'h0, 8'hEE, 1'b1);
    chk("R8", "upper write count", wr_cnt - wc, 0);
    b = lin_b(2, 'h10);
    chk("R8", "alias untouched", memb(b / 4, b % 4), pat(b / 4, b % 4));
    rd(17'h10010, 2, 1'b1, 4'h0, 8'h00, "R8");
    chk("R8", "upper read count", re_cnt - rc, 0);

    // legacy forwarding
    ext_en = 1'b0; wc = wr_cnt; rc = re_cnt;
    host_addr = 17'h1ABCD; host_wdata = 8'h5E; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
    chk("R9", "legacy write", {legacy_wr, legacy_addr, legacy_wdata}, {1'b1, 17'h1ABCD, 8'h5E});
    host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
    chk("R9", "legacy read", {legacy_rd, legacy_wr}, 2'b10);
    repeat (4) @(negedge clk);
    chk("R9", "no memory access", (wr_cnt - wc) + (re_cnt - rc), 0);
    ext_en = 1'b1;

    // strobes during a burst are ignored
    wc = wr_cnt; rc = re_cnt;
    host_addr = 17'h00200; bank_wr = 6'd1; chain4 = 1'b0; map_mask = 4'b1111;
    host_wdata = 8'h11; host_wr = 1'b1;
    @(negedge clk);
    host_addr = 17'h00300; chain4 = 1'b1; host_wdata = 8'h99;
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R11", "burst writes only", wr_cnt - wc, 4);
    chk("R11", "no read issued", re_cnt - rc, 0);
    b = lin_b(1, 'h300);
    chk("R11", "ignored write", memb(b / 4, b % 4), pat(b / 4, b % 4));
    chk("R3", "all planes", {memb(pl_w(1, 'h200), 0), memb(pl_w(1, 'h200), 3)}, 16'h1111);

    // read and write together
    wc = wr_cnt; rc = re_cnt;
    host_addr = 17'h00040; bank_wr = 6'd3; bank_rd = 6'd3; chain4 = 1'b1;
    host_wdata = 8'h6B; host_wr = 1'b1; host_rd = 1'b1;
    @(negedge clk); host_wr = 1'b0; host_rd = 1'b0;
    repeat (4) @(negedge clk);
    chk("R12", "write taken", wr_cnt - wc, 1);
    chk("R12", "read dropped", re_cnt - rc, 0);
    b = lin_b(3, 'h40);
    chk("R12", "written byte", memb(b / 4, b % 4), 8'h6B);

    // read in the cycle the burst ends: must see the last plane
    wr(17'h00500, 4, 1'b0, 4'b1111, 8'h5A, 1'b0);
    rd(17'h00500, 4, 1'b0, 4'b1000, 8'h5A, "R4");

    repeat (3) @(negedge clk);
    chk("R10", "outstanding reads", exp_q.size(), 0);
    finish_run();
  end
endmodule